// File: doc/BRIEF.md
# Column-Scanned Dot Matrix Refresh Controller

This block keeps a four-character, 5x7 LED dot matrix lit without host attention. The host deposits pre-decoded column patterns into a 20-entry store of 7-bit words. The controller then walks the five columns without end. For each column it serialises 28 row bits to the display's shift register over a generated shift clock. With the data in place it raises that column's strobe for a fixed dwell, then moves to the next column.

Brightness comes from a 4-bit level. The level pulse-width-modulates the active-high blanking enable inside every dwell, and a level of zero keeps the display dark. The host write port is a valid/ready stream. Ready is held high at all times, so a write is accepted in every cycle in which valid is high and there is never back-pressure. Brightness is a plain control input.

Top module: `dotmatrix_refresh`

## Requirements
- R1: While reset is asserted and just after it, every column strobe is low, `blank_n` is low, `sclk` is high, and the load of column 1 starts from an all-zero store.
- R2: During a load, `sclk` spends exactly HALF_DIV system clocks high and then HALF_DIV clocks low for each bit, and it idles high outside loads. `sdata` changes only together with a rising `sclk`, never at a falling one.
- R3: Each column load gives exactly 28 bits. Character 4 goes first and character 1 last. Inside a character the order is row 7 down to row 1.
- R4: Store address = character_index*5 + column_index, where index 0 means character 1 or column 1. Bit r-1 of a word is row r, and a 1 lights the LED.
- R5: All strobes are low during a load. After the 28th bit's low phase, only `col_strobe[c]` is high for DWELL system clocks. The columns run 1 to 5 and then wrap back to 1.
- R6: A column's 28 bits are taken from the store on the clock edge that starts its load. A write on that same edge, or on any later edge, does not change the column being shifted.
- R7: `blank_n` is low outside dwells. In dwell cycle k (counted from 0), `blank_n` is high exactly when (k mod 16) < the latched brightness, so a brightness of 0 keeps it low throughout.
- R8: `bright` is sampled on the edge that ends a load. A change made during a dwell first takes effect in the next dwell.
- R9: `wr_ready` is always high. A write whose address is 20 or more leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write acceptance, always high |
| wr_addr | input | 5 | Store address, character_index*5 + column_index |
| wr_data | input | 7 | Row pattern, bit 0 = row 1 |
| bright | input | 4 | Brightness level, 0 = dark |
| sclk | output | 1 | Display shift clock, data taken on its falling edge |
| sdata | output | 1 | Serial row data |
| col_strobe | output | 5 | Column enables, bit 0 = column 1 |
| blank_n | output | 1 | Display enable, low = blank |

## Verification
The case hardest to reach is a host write that lands on the very edge at which a column's bits are captured. Whether the old or the new word is shifted there decides if a column tears. The bench uses a short divider and dwell so that capture edges come often. It then drives writes to random addresses on every cycle for thousands of cycles, so that many capture edges meet a simultaneous write to the column being captured. A behavioural model that captures first and writes second is compared on every clock.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int CHARS      = 4;
  localparam int COLS       = 5;
  localparam int ROWS       = 7;
  localparam int FRAME_BITS = CHARS * ROWS;
  localparam int CELLS      = CHARS * COLS;
  localparam int ADDR_W     = $clog2(CELLS);
  localparam int COL_W      = $clog2(COLS);
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef logic [ROWS-1:0]       rowpat_t;
  typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/dm_buffer.sv
module dm_buffer
  import dm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  rowpat_t           wr_data,
  input  logic [COL_W-1:0]  rd_col,
  output frame_t            rd_frame
);
  rowpat_t cell_q [CELLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) cell_q[i] <= '0;
    end else if (wr_en && (wr_addr < ADDR_W'(CELLS))) begin
      cell_q[wr_addr] <= wr_data;
    end
  end

  // Character 4 occupies the top group so that it leaves the shifter first.
  for (genvar c = 0; c < CHARS; c++) begin : g_group
    logic [ADDR_W-1:0] idx;
    assign idx = ADDR_W'(c * COLS) + ADDR_W'(rd_col);
    assign rd_frame[c*ROWS +: ROWS] = cell_q[idx];
  end
endmodule

// File: rtl/dm_serializer.sv
module dm_serializer
  import dm_pkg::*;
#(
  parameter int HALF_DIV = 13
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t frame,
  output logic   sclk,
  output logic   sdata,
  output logic   busy,
  output logic   done
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);

  logic             busy_q, low_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  frame_t           sh_q;
  logic             half_end;

  assign half_end = busy_q && (div_q == DIV_W'(HALF_DIV - 1));
  assign done     = half_end && low_q && (bit_q == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      low_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      low_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= frame;
    end else if (busy_q) begin
      if (half_end) begin
        div_q <= '0;
        if (!low_q) begin
          low_q <= 1'b1;
        end else begin
          low_q <= 1'b0;
          sh_q  <= sh_q << 1;
          if (done) busy_q <= 1'b0;
          else      bit_q  <= bit_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk  = busy_q ? ~low_q : 1'b1;
  assign sdata = sh_q[FRAME_BITS-1];
  assign busy  = busy_q;

  // Low-phase length monitor for the shift clock.
  logic [DIV_W:0] lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_run_q <= '0;
    else if (sclk) lo_run_q <= '0;
    else           lo_run_q <= lo_run_q + 1'b1;
  end

  p_low_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && lo_run_q != '0) |-> (lo_run_q == (DIV_W+1)'(HALF_DIV)));

  p_data_steady_at_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdata));
endmodule

// File: rtl/dm_pwm.sv
module dm_pwm #(
  parameter int LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               active,
  input  logic [LEVEL_W-1:0] level,
  output logic               on
);
  logic [LEVEL_W-1:0] cnt_q, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      lvl_q <= level;
    end else if (active) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign on = active && (cnt_q < lvl_q);
endmodule

// File: rtl/dotmatrix_refresh.sv
module dotmatrix_refresh
  import dm_pkg::*;
#(
  parameter int HALF_DIV = 13,
  parameter int DWELL    = 256,
  parameter int BRIGHT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [ROWS-1:0]     wr_data,
  input  logic [BRIGHT_W-1:0] bright,
  output logic                sclk,
  output logic                sdata,
  output logic [COLS-1:0]     col_strobe,
  output logic                blank_n
);
  localparam int DW_W = $clog2(DWELL + 1);

  logic             ser_busy, ser_done, dwell_end;
  logic [COL_W-1:0] col_q, next_col;
  logic [DW_W-1:0]  dw_q;
  frame_t           frame;

  assign wr_ready  = 1'b1;
  assign next_col  = (col_q == COL_W'(COLS - 1)) ? '0 : col_q + 1'b1;
  assign dwell_end = !ser_busy && (dw_q == DW_W'(DWELL - 1));

  dm_buffer u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_col   (next_col),
    .rd_frame (frame)
  );

  dm_serializer #(.HALF_DIV(HALF_DIV)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dwell_end),
    .frame (frame),
    .sclk  (sclk),
    .sdata (sdata),
    .busy  (ser_busy),
    .done  (ser_done)
  );

  dm_pwm #(.LEVEL_W(BRIGHT_W)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ser_done),
    .active (!ser_busy),
    .level  (bright),
    .on     (blank_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      dw_q  <= '0;
    end else if (ser_done) begin
      dw_q  <= '0;
    end else if (dwell_end) begin
      dw_q  <= '0;
      col_q <= next_col;
    end else if (!ser_busy) begin
      dw_q  <= dw_q + 1'b1;
    end
  end

  for (genvar k = 0; k < COLS; k++) begin : g_strobe
    assign col_strobe[k] = !ser_busy && (col_q == COL_W'(k));
  end

  p_dark_while_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> (col_strobe == '0));

  p_single_column_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_strobe));

  p_blank_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_strobe == '0) |-> !blank_n);
endmodule

// File: tb/dotmatrix_refresh_tb.sv
module dotmatrix_refresh_tb;
  localparam int HD = 3;
  localparam int DW = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [3:0] bright = '0;
  logic       wr_ready, sclk, sdata, blank_n;
  logic [4:0] col_strobe;

  always #4 clk = ~clk;

  dotmatrix_refresh #(.HALF_DIV(HD), .DWELL(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .bright(bright), .sclk(sclk),
    .sdata(sdata), .col_strobe(col_strobe), .blank_n(blank_n)
  );

  // Behavioural reference
  int   m_dwell, m_col, m_bits, m_hi, m_sub, m_dw, m_brl;
  bit   m_q[$];
  logic [6:0] m_buf [20];
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 0;

  function automatic void fill_column(int col);
    m_q.delete();
    for (int c = 3; c >= 0; c--)
      for (int r = 6; r >= 0; r--) m_q.push_back(m_buf[c*5 + col][r]);
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 20; i++) m_buf[i] = '0;
    m_dwell = 0; m_col = 0; m_bits = 0; m_hi = 1; m_sub = 0; m_dw = 0; m_brl = 0;
    fill_column(0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (m_dwell == 0) begin
        m_sub++;
        if (m_sub == HD) begin
          m_sub = 0;
          if (m_hi == 1) m_hi = 0;
          else begin
            m_hi = 1;
            void'(m_q.pop_front());
            m_bits++;
            if (m_bits == 28) begin m_dwell = 1; m_dw = 0; m_brl = int'(bright); end
          end
        end
      end else if (m_dw == DW - 1) begin
        m_col = (m_col + 1) % 5;
        m_dwell = 0; m_bits = 0; m_hi = 1; m_sub = 0;
        fill_column(m_col);      // capture before any same-edge write (R6)
      end else m_dw++;
      if (wr_valid && wr_addr < 20) m_buf[wr_addr] = wr_data;   // R9 range
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 sclk", sclk, m_dwell ? 1 : m_hi);
      check("R3 R4 R6 R9 sdata", sdata, (m_q.size() > 0) ? m_q[0] : 0);
      check("R5 col_strobe", col_strobe, m_dwell ? (1 << m_col) : 0);
      check("R7 R8 blank_n", blank_n, (m_dwell && ((m_dw % 16) < m_brl)) ? 1 : 0);
      check("R9 wr_ready", wr_ready, 1);
    end
  end

  task automatic drive(bit v, int a, int d, int b);
    @(negedge clk); #1;
    wr_valid = v; wr_addr = 5'(a); wr_data = 7'(d); bright = 4'(b);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 sclk", sclk, 1);
    check("R1 col_strobe", col_strobe, 0);
    check("R1 blank_n", blank_n, 0);
    check("R1 sdata", sdata, 0);
    #1 rst_n = 1'b1;
    // R3 R4: distinct pattern in every cell, full brightness
    for (int i = 0; i < 20; i++) drive(1, i, (i*37 + 5) & 7'h7f, 15);
    drive(0, 0, 0, 15);
    repeat (3200) @(negedge clk);
    // R7: brightness zero keeps the display dark
    drive(0, 0, 0, 0);
    repeat (1100) @(negedge clk);
    // R8: brightness changes on every cycle
    for (int i = 0; i < 1500; i++) drive(0, 0, 0, $urandom_range(15, 0));
    // R9: out-of-range writes are dropped
    for (int i = 0; i < 1000; i++) drive(1, $urandom_range(31, 20), $urandom, 12);
    // R6: writes on every cycle, meeting capture edges
    for (int i = 0; i < 3000; i++) drive(1, $urandom_range(31, 0), $urandom, 9);
    drive(0, 0, 0, 5);
    repeat (2200) @(negedge clk);
    summary();
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule